// File: doc/BRIEF.md
# Deblocking Edge Decision Unit

This unit looks at a row of sixteen pixels straddling a block edge, eight on the near side (p7 out to p0, nearest the edge) and eight on the far side (q0 nearest the edge out to q7). It does this for several lanes at once. For each lane it decides whether smoothing is allowed at all and whether the edge shows high variance. It also decides whether the four pixels on each side are flat enough for the medium filter, and whether all eight on each side are flat enough for the wide filter. Those four flags steer a downstream filter bank. That filter bank, the pixel fetch and the threshold storage live elsewhere.

Three unsigned thresholds travel with each pixel vector: an edge limit, an interior limit and a variance threshold. Every test works on unsigned absolute pixel differences. The flags of all lanes are registered once and appear together, one cycle after the input, under a single valid strobe.

A two-state controller tracks output validity. `ST_IDLE` means no fresh result is held; `ST_EMIT` means the flag registers took a new vector on the last edge. The transition `go_emit` (IDLE to EMIT) and the transition `stay_emit` (EMIT to EMIT) both fire on `in_valid_i`. The transition `go_idle` (EMIT to IDLE) and the transition `stay_idle` (IDLE to IDLE) fire when `in_valid_i` is low.

Top module: `edge_decision_unit`

## Requirements
- R1: While reset is asserted and after its release, until the first accepted vector, `out_valid_o` and all four flag vectors are 0.
- R2: A vector accepted with `in_valid_i` high at a clock edge produces its flags, with `out_valid_o` high, right after the next rising edge. `out_valid_o` is low after any edge at which `in_valid_i` was low.
- R3: At an edge with `in_valid_i` low, the flag outputs keep their previous values whatever is on the pixel and threshold inputs.
- R4: Bit L of `hev_o` is 1 exactly when max(|p1-p0|, |q1-q0|) of lane L is strictly greater than `var_thr_i`.
- R5: The edge term is sat(sat(2·|p0-q0|) + (|p1-q1| >> 1)), where sat clamps to 255. The lane fails when this term is strictly greater than `edge_lim_i`.
- R6: The lane fails when any of |p3-p2|, |p2-p1|, |p1-p0|, |q1-q0|, |q2-q1| or |q3-q2| is strictly greater than `inner_lim_i`.
- R7: Bit L of `mask_o` is 1 exactly when lane L fails neither the R5 test nor the R6 test.
- R8: Bit L of `flat_o` is 1 exactly when |p1-p0|, |q1-q0|, |p2-p0|, |q2-q0|, |p3-p0| and |q3-q0| are all at most 1 and mask bit L is 1.
- R9: Bit L of `flat2_o` is 1 exactly when |pk-p0| and |qk-q0| are at most 1 for every k from 4 to 7 and flat bit L is 1.
- R10: Pixel k of lane L sits at `pix_i[(L*16+k)*8 +: 8]`. Index k=0 is p7, k=7 is p0, k=8 is q0 and k=15 is q7. Each flag output carries lane L in bit L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Pixel vector and thresholds are valid this cycle |
| pix_i | input | 2048 | Pixels of all lanes, layout per R10 |
| edge_lim_i | input | 8 | Edge limit for the weighted centre test |
| inner_lim_i | input | 8 | Interior limit for neighbour differences |
| var_thr_i | input | 8 | High-variance threshold |
| out_valid_o | output | 1 | Flags below belong to the vector accepted on the previous edge |
| mask_o | output | 16 | Filter-enable flag per lane |
| hev_o | output | 16 | High-edge-variance flag per lane |
| flat_o | output | 16 | Four-pixel flatness flag per lane |
| flat2_o | output | 16 | Eight-pixel flatness flag per lane |

## Verification
The sharpest case is the saturating edge term: a centre step of 200 doubles to 400. A design without the clamp wraps that to 144 and wrongly enables a lane that an edge limit of 254 should reject. Equality at every threshold is probed, since a design that used greater-or-equal would drop lanes that sit exactly on the limit. Single-lane disturbances at p1 and q7 expose swapped lane or pixel ordering, or a flat2 that ignores its flat qualifier. Idle cycles with scrambled inputs catch registers that load without a valid strobe.

// File: rtl/edge_dec_pkg.sv
package edge_dec_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } dec_state_t;
endpackage

// File: rtl/edge_lane_mask.sv
module edge_lane_mask #(
    parameter int PIX_W = 8,
    parameter int TAPS  = 16
) (
    input  logic [TAPS-1:0][PIX_W-1:0] px_i,
    input  logic [PIX_W-1:0]           edge_lim_i,
    input  logic [PIX_W-1:0]           inner_lim_i,
    input  logic [PIX_W-1:0]           var_thr_i,
    output logic                       mask_o,
    output logic                       hev_o
);
    localparam int IP0 = TAPS/2 - 1;
    localparam int IQ0 = TAPS/2;

    function automatic logic [PIX_W-1:0] adiff(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    logic [PIX_W-1:0] d_p3p2, d_p2p1, d_p1p0, d_q1q0, d_q2q1, d_q3q2;
    logic [PIX_W-1:0] d_p0q0, d_p1q1, max_nb, dbl_sat, edge_term;
    logic [PIX_W:0]   dbl_raw, sum_raw;
    logic             fail_edge, fail_inner;

    always_comb begin
        d_p3p2 = adiff(px_i[IP0-3], px_i[IP0-2]);
        d_p2p1 = adiff(px_i[IP0-2], px_i[IP0-1]);
        d_p1p0 = adiff(px_i[IP0-1], px_i[IP0]);
        d_q1q0 = adiff(px_i[IQ0+1], px_i[IQ0]);
        d_q2q1 = adiff(px_i[IQ0+2], px_i[IQ0+1]);
        d_q3q2 = adiff(px_i[IQ0+3], px_i[IQ0+2]);
        d_p0q0 = adiff(px_i[IP0],   px_i[IQ0]);
        d_p1q1 = adiff(px_i[IP0-1], px_i[IQ0+1]);

        max_nb = (d_p1p0 > d_q1q0) ? d_p1p0 : d_q1q0;
        hev_o  = max_nb > var_thr_i;

        dbl_raw   = {d_p0q0, 1'b0};
        dbl_sat   = dbl_raw[PIX_W] ? '1 : dbl_raw[PIX_W-1:0];
        sum_raw   = (PIX_W+1)'(dbl_sat) + (PIX_W+1)'(d_p1q1 >> 1);
        edge_term = sum_raw[PIX_W] ? '1 : sum_raw[PIX_W-1:0];
        fail_edge = edge_term > edge_lim_i;

        fail_inner = (d_p3p2 > inner_lim_i) || (d_p2p1 > inner_lim_i) ||
                     (d_p1p0 > inner_lim_i) || (d_q1q0 > inner_lim_i) ||
                     (d_q2q1 > inner_lim_i) || (d_q3q2 > inner_lim_i);

        mask_o = !(fail_edge || fail_inner);
    end
endmodule

// File: rtl/edge_lane_flat.sv
module edge_lane_flat #(
    parameter int PIX_W = 8,
    parameter int TAPS  = 16
) (
    input  logic [TAPS-1:0][PIX_W-1:0] px_i,
    input  logic                       mask_i,
    output logic                       flat_o,
    output logic                       flat2_o
);
    localparam int IP0   = TAPS/2 - 1;
    localparam int IQ0   = TAPS/2;
    localparam int NEAR  = 3;
    localparam int SIDE  = TAPS/2 - 1;

    function automatic logic [PIX_W-1:0] adiff(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    logic near_ok, far_ok;

    always_comb begin
        near_ok = 1'b1;
        far_ok  = 1'b1;
        for (int k = 1; k <= SIDE; k++) begin
            if (k <= NEAR) begin
                if (adiff(px_i[IP0-k], px_i[IP0]) > PIX_W'(1)) near_ok = 1'b0;
                if (adiff(px_i[IQ0+k], px_i[IQ0]) > PIX_W'(1)) near_ok = 1'b0;
            end else begin
                if (adiff(px_i[IP0-k], px_i[IP0]) > PIX_W'(1)) far_ok = 1'b0;
                if (adiff(px_i[IQ0+k], px_i[IQ0]) > PIX_W'(1)) far_ok = 1'b0;
            end
        end
        flat_o  = near_ok && mask_i;
        flat2_o = far_ok && flat_o;
    end
endmodule

// File: rtl/edge_decision_unit.sv
module edge_decision_unit
    import edge_dec_pkg::*;
#(
    parameter int LANES = 16,
    parameter int PIX_W = 8,
    parameter int TAPS  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid_i,
    input  logic [LANES*TAPS*PIX_W-1:0]    pix_i,
    input  logic [PIX_W-1:0]               edge_lim_i,
    input  logic [PIX_W-1:0]               inner_lim_i,
    input  logic [PIX_W-1:0]               var_thr_i,
    output logic                           out_valid_o,
    output logic [LANES-1:0]               mask_o,
    output logic [LANES-1:0]               hev_o,
    output logic [LANES-1:0]               flat_o,
    output logic [LANES-1:0]               flat2_o
);
    localparam int LANE_W = TAPS * PIX_W;

    dec_state_t       state_q, state_d;
    logic [LANES-1:0] mask_c, hev_c, flat_c, flat2_c;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [TAPS-1:0][PIX_W-1:0] lane_px;
        assign lane_px = pix_i[l*LANE_W +: LANE_W];

        edge_lane_mask #(.PIX_W(PIX_W), .TAPS(TAPS)) u_mask (
            .px_i        (lane_px),
            .edge_lim_i  (edge_lim_i),
            .inner_lim_i (inner_lim_i),
            .var_thr_i   (var_thr_i),
            .mask_o      (mask_c[l]),
            .hev_o       (hev_c[l])
        );

        edge_lane_flat #(.PIX_W(PIX_W), .TAPS(TAPS)) u_flat (
            .px_i    (lane_px),
            .mask_i  (mask_c[l]),
            .flat_o  (flat_c[l]),
            .flat2_o (flat2_c[l])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid_i ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid_i ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o  <= '0;
            hev_o   <= '0;
            flat_o  <= '0;
            flat2_o <= '0;
        end else if (in_valid_i) begin
            mask_o  <= mask_c;
            hev_o   <= hev_c;
            flat_o  <= flat_c;
            flat2_o <= flat2_c;
        end
    end

    assign out_valid_o = (state_q == ST_EMIT);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> ($stable(mask_o) && $stable(hev_o) && $stable(flat_o) && $stable(flat2_o)));

    // R8
    flat_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flat_o & ~mask_o) == '0);

    // R9
    flat2_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flat2_o & ~flat_o) == '0);
endmodule

// File: tb/edge_decision_unit_tb.sv
module edge_decision_unit_tb;
    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid_i;
    logic [2047:0] pix_i;
    logic [7:0]    edge_lim_i, inner_lim_i, var_thr_i;
    logic          out_valid_o;
    logic [15:0]   mask_o, hev_o, flat_o, flat2_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] pxa [16][16];
    logic [15:0] e_mask, e_hev, e_flat, e_flat2;

    always #10 clk = ~clk;

    edge_decision_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .pix_i(pix_i),
        .edge_lim_i(edge_lim_i), .inner_lim_i(inner_lim_i), .var_thr_i(var_thr_i),
        .out_valid_o(out_valid_o), .mask_o(mask_o), .hev_o(hev_o),
        .flat_o(flat_o), .flat2_o(flat2_o)
    );

    function automatic int ad(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // returns {mask, hev, flat, flat2} for one lane; index 7 = p0, 8 = q0
    function automatic logic [3:0] ref_lane(input int l, input int bl, input int il, input int vt);
        int p[8], q[8];
        int dbl, term, mx;
        bit m, h, f, f2;
        for (int k = 0; k < 8; k++) begin
            p[k] = pxa[l][7-k];
            q[k] = pxa[l][8+k];
        end
        mx = (ad(p[1],p[0]) > ad(q[1],q[0])) ? ad(p[1],p[0]) : ad(q[1],q[0]);
        h = mx > vt;
        dbl = 2 * ad(p[0], q[0]);
        if (dbl > 255) dbl = 255;
        term = dbl + ad(p[1], q[1]) / 2;
        if (term > 255) term = 255;
        m = !(term > bl);
        for (int k = 1; k <= 3; k++) begin
            if (ad(p[k], p[k-1]) > il) m = 1'b0;
            if (ad(q[k], q[k-1]) > il) m = 1'b0;
        end
        f = m;
        for (int k = 1; k <= 3; k++)
            if (ad(p[k], p[0]) > 1 || ad(q[k], q[0]) > 1) f = 1'b0;
        f2 = f;
        for (int k = 4; k <= 7; k++)
            if (ad(p[k], p[0]) > 1 || ad(q[k], q[0]) > 1) f2 = 1'b0;
        return {m, h, f, f2};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill_const(input int v);
        for (int l = 0; l < 16; l++)
            for (int k = 0; k < 16; k++) pxa[l][k] = 8'(v);
    endtask

    task automatic compute_exp();
        logic [3:0] r;
        for (int l = 0; l < 16; l++) begin
            r = ref_lane(l, edge_lim_i, inner_lim_i, var_thr_i);
            e_mask[l] = r[3]; e_hev[l] = r[2]; e_flat[l] = r[1]; e_flat2[l] = r[0];
        end
    endtask

    // drive at negedge, capture at posedge, check at the following negedge
    task automatic apply_vec(input logic [7:0] bl, input logic [7:0] il, input logic [7:0] vt);
        for (int l = 0; l < 16; l++)
            for (int k = 0; k < 16; k++) pix_i[(l*16+k)*8 +: 8] = pxa[l][k];
        edge_lim_i = bl; inner_lim_i = il; var_thr_i = vt;
        in_valid_i = 1'b1;
        compute_exp();
        @(negedge clk);
        in_valid_i = 1'b0;
        chk("R2 valid", {15'd0, out_valid_o}, 16'd1);
        chk("R7 mask", mask_o, e_mask);
        chk("R4 hev", hev_o, e_hev);
        chk("R8 flat", flat_o, e_flat);
        chk("R9 flat2", flat2_o, e_flat2);
    endtask

    task automatic idle_cycle();
        pix_i = {64{$urandom()}};
        edge_lim_i = 8'($urandom()); inner_lim_i = 8'($urandom()); var_thr_i = 8'($urandom());
        in_valid_i = 1'b0;
        @(negedge clk);
        chk("R2 idle valid", {15'd0, out_valid_o}, 16'd0);
        chk("R3 hold mask", mask_o, e_mask);
        chk("R3 hold hev", hev_o, e_hev);
        chk("R3 hold flat", flat_o, e_flat);
        chk("R3 hold flat2", flat2_o, e_flat2);
    endtask

    function automatic int clamp(input int v);
        return (v < 0) ? 0 : (v > 255) ? 255 : v;
    endfunction

    task automatic fill_random();
        int mode, base, spread;
        for (int l = 0; l < 16; l++) begin
            mode = int'($urandom() % 4);
            base = int'($urandom() % 256);
            spread = (mode == 1) ? 1 : (mode == 2) ? 3 : 1;
            for (int k = 0; k < 16; k++) begin
                if (mode == 0 || (mode == 3 && (k < 4 || k > 11)))
                    pxa[l][k] = 8'($urandom());
                else
                    pxa[l][k] = 8'(clamp(base + int'($urandom() % (2*spread+1)) - spread));
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid_i = 1'b0; pix_i = '0;
        edge_lim_i = '0; inner_lim_i = '0; var_thr_i = '0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 valid in reset", {15'd0, out_valid_o}, 16'd0);
        chk("R1 flags in reset", mask_o | hev_o | flat_o | flat2_o, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {15'd0, out_valid_o}, 16'd0);
        chk("R1 flags after reset", mask_o | hev_o | flat_o | flat2_o, 16'd0);

        // all equal, zero thresholds: equality must pass (R5, R6, R4)
        fill_const(90);
        apply_vec(8'd0, 8'd0, 8'd0);
        chk("R5 zero term at zero limit", mask_o, 16'hFFFF);

        // R5 saturation: centre step 200 saturates to 255
        fill_const(50);
        for (int k = 0; k < 8; k++) pxa[0][k] = 8'd0;
        for (int k = 8; k < 16; k++) pxa[0][k] = 8'd200;
        apply_vec(8'd254, 8'd255, 8'd255);
        chk("R5 saturated term above 254", {15'd0, mask_o[0]}, 16'd0);
        apply_vec(8'd255, 8'd255, 8'd255);
        chk("R5 saturated term equals 255", {15'd0, mask_o[0]}, 16'd1);
        idle_cycle();

        // R6 interior limit: lane 3 exceeds by one, lane 9 equal
        fill_const(100);
        pxa[3][4]  = 8'd105;
        pxa[9][11] = 8'd104;
        apply_vec(8'd255, 8'd4, 8'd255);
        chk("R6 above interior limit", {15'd0, mask_o[3]}, 16'd0);
        chk("R6 equal interior limit", {15'd0, mask_o[9]}, 16'd1);
        chk("R8 flat off at distance 4", {15'd0, flat_o[9]}, 16'd0);

        // R10 lane and pixel ordering
        fill_const(100);
        pxa[5][6]   = 8'd103;
        pxa[15][15] = 8'd101;
        pxa[12][0]  = 8'd110;
        apply_vec(8'd255, 8'd255, 8'd2);
        chk("R10 hev lane 5 only", hev_o, 16'h0020);
        chk("R10 flat", flat_o, 16'hFFDF);
        chk("R10 flat2", flat2_o, 16'hEFDF);
        idle_cycle();

        // random mix
        for (int n = 0; n < 400; n++) begin
            fill_random();
            apply_vec(8'($urandom()), 8'($urandom() % 24), 8'($urandom() % 8));
            if (($urandom() % 4) == 0) idle_cycle();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule